// File: doc/BRIEF.md
# UART Receive Queue with Character Error Status

This block sits between the bit-level deserialiser of a UART receiver and the host's register decode. The deserialiser hands over each finished character together with three condition flags: a stop bit was missing (framing), the parity check failed, and the line was held in the spacing state (break). The block holds each character and its flags in a small first-in first-out queue. It also builds the receiver's status byte, an interrupt request and an automatic request-to-send line.

There are two ways to report errors. In per-character mode the status byte shows the flags of the character at the head of the queue, and those flags go away when the character is read. In accumulate mode the status shows the OR of the flags of every character taken in since the last clear. Those bits stay set until the host issues an error-clear command or resets the receiver.

Overrun is raised when a character arrives and the queue has no room. The stored characters are kept unchanged. Enable, disable, receiver reset and error clear arrive as one-cycle command pulses. The mode inputs are configuration and are expected to stay static while traffic flows.

Top module: `uart_rxq_stat`

## Requirements
- R1: After `rst` the queue is empty, the receiver is disabled, overrun and the accumulated flags are clear, `irq` is 0 and `rts` is 1.
- R2: A `cmd_rx_on` pulse enables the receiver and a `cmd_rx_off` pulse disables it. If both pulse in the same cycle, disable wins. While the receiver is disabled, `rx_valid` is ignored: nothing is stored and overrun is not set.
- R3: The queue holds DEPTH characters (3 by default) and returns them in arrival order. `rd_data` shows the head character, or 0 when the queue is empty. A `rd_pop` pulse removes the head. A `rd_pop` on an empty queue has no effect.
- R4: Status bit 1 is 1 exactly when the queue is full. Status bit 0 is 1 when at least one character is held. Bit 3 mirrors `tx_empty_in` and bit 2 mirrors `tx_ready_in`.
- R5: With `mode_block`=0, status bits 7, 6 and 5 show the break, framing and parity flags of the head character, in that order. These bits are 0 when the queue is empty. The flags leave together with their character on a pop.
- R6: With `mode_block`=1, status bits 7:5 show the OR of the break/framing/parity flags of all characters accepted since the last error clear or receiver reset. The bits stay set after the characters are read.
- R7: A character that arrives while the receiver is enabled, the queue is full and no pop occurs in the same cycle sets status bit 4 (overrun). That character is dropped and the stored characters are left unchanged. Overrun stays set while the queue drains.
- R8: A `cmd_err_clr` pulse clears overrun, the accumulated flags and the flags of the characters already stored. The stored data characters are kept.
- R9: A `cmd_rx_reset` pulse empties the queue, clears all flags and overrun, and disables the receiver. It takes priority over every other input in the same cycle.
- R10: `irq` equals status bit 0 when `mode_irq_full`=0 and status bit 1 when `mode_irq_full`=1.
- R11: With `mode_auto_rts`=1, `rts` is 0 while the queue is full and 1 otherwise. With `mode_auto_rts`=0, `rts` stays at 1.
- R12: When a character arrives in the same cycle as a pop on a full queue, both take effect. The queue stays full, overrun is not set, and order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a character is ready from the deserialiser |
| rx_char | input | 8 | Received character |
| rx_ferr | input | 1 | Framing flag for `rx_char` |
| rx_perr | input | 1 | Parity flag for `rx_char` |
| rx_brk | input | 1 | Break flag for `rx_char` |
| cmd_rx_on | input | 1 | Command pulse: enable receiver |
| cmd_rx_off | input | 1 | Command pulse: disable receiver |
| cmd_rx_reset | input | 1 | Command pulse: receiver reset |
| cmd_err_clr | input | 1 | Command pulse: clear error status |
| mode_block | input | 1 | 0 per-character error mode, 1 accumulate mode |
| mode_irq_full | input | 1 | Interrupt source: 0 not-empty, 1 full |
| mode_auto_rts | input | 1 | 1 lets queue fullness drive `rts` |
| rd_pop | input | 1 | Host read strobe: remove head character |
| tx_empty_in | input | 1 | Transmitter-empty flag shown in status bit 3 |
| tx_ready_in | input | 1 | Transmitter-ready flag shown in status bit 2 |
| rd_data | output | 8 | Head character, 0 when empty |
| status | output | 8 | Status byte |
| irq | output | 1 | Receiver interrupt request |
| rts | output | 1 | Request-to-send, 1 = asserted |

## Verification
Some properties are checked on every cycle by the embedded assertions. The fill level never goes above the depth. An arrival at a full, enabled, non-draining queue raises overrun on the next cycle. A disabled receiver never changes the fill level on its own. A receiver reset or an error clear leaves the flags clean on the next cycle. An accumulated flag cannot drop without a clear. Other behaviours only show up in the directed scenarios: which bytes come out and in what order, the way head flags follow their character, the rule that a dropped character never reaches the output, the interrupt and request-to-send selection, and the combined push-and-pop on a full queue.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  // Per-character line conditions, packed in status-bit order (7:5)
  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rx_flags_t;

  localparam int FLAG_W = 3;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic             clr_flags,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  rx_flags_t        wr_flags,
  input  logic             rd_en,
  output logic [DW-1:0]    head_data,
  output rx_flags_t        head_flags,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  rx_flags_t     flg [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_rd;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign do_rd = rd_en && !empty;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Data array: no reset, so it maps to distributed or block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  // Flag array is kept in flops so a clear can wipe every entry at once
  always_ff @(posedge clk) begin
    if (rst || clr_all || clr_flags) begin
      for (int i = 0; i < DEPTH; i++) flg[i] <= '0;
    end
    if (!rst && !clr_all && wr_en) flg[wr_ptr] <= wr_flags;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= step(wr_ptr);
      if (do_rd) rd_ptr <= step(rd_ptr);
      case ({wr_en, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_data  = empty ? '0 : mem[rd_ptr];
  assign head_flags = empty ? '0 : flg[rd_ptr];

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R7
  no_full_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full) |-> rd_en);
endmodule

// File: rtl/rxq_errs.sv
module rxq_errs
  import uart_rxq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      clr_all,
  input  logic      clr_err,
  input  logic      arrive,
  input  logic      q_full,
  input  logic      popping,
  input  rx_flags_t new_flags,
  output logic      overrun,
  output rx_flags_t accum
);
  logic ovr_hit;
  assign ovr_hit = arrive && q_full && !popping;

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      overrun <= 1'b0;
      accum   <= '0;
    end else begin
      if (clr_err)      overrun <= 1'b0;
      else if (ovr_hit) overrun <= 1'b1;
      if (arrive && !ovr_hit) accum <= (clr_err ? '0 : accum) | new_flags;
      else if (clr_err)       accum <= '0;
    end
  end

  // R7
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (arrive && q_full && !popping && !clr_err && !clr_all) |=> overrun);

  // R6
  accum_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (accum.perr && !clr_err && !clr_all) |=> accum.perr);

  // R8
  err_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_err && !arrive) |=> (!overrun && accum == '0));
endmodule

// File: rtl/uart_rxq_stat.sv
module uart_rxq_stat
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_char,
  input  logic          rx_ferr,
  input  logic          rx_perr,
  input  logic          rx_brk,
  input  logic          cmd_rx_on,
  input  logic          cmd_rx_off,
  input  logic          cmd_rx_reset,
  input  logic          cmd_err_clr,
  input  logic          mode_block,
  input  logic          mode_irq_full,
  input  logic          mode_auto_rts,
  input  logic          rd_pop,
  input  logic          tx_empty_in,
  input  logic          tx_ready_in,
  output logic [DW-1:0] rd_data,
  output logic [7:0]    status,
  output logic          irq,
  output logic          rts
);
  logic      rx_en, arrive, wr_ok, q_full, q_empty;
  rx_flags_t in_flags, head_flags, accum, shown;
  logic      overrun;

  assign in_flags = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr};
  assign arrive   = rx_en && rx_valid && !cmd_rx_reset;
  assign wr_ok    = arrive && (!q_full || rd_pop);

  always_ff @(posedge clk) begin
    if (rst || cmd_rx_reset) rx_en <= 1'b0;
    else if (cmd_rx_off)     rx_en <= 1'b0;
    else if (cmd_rx_on)      rx_en <= 1'b1;
  end

  rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk        (clk),
    .rst        (rst),
    .clr_all    (cmd_rx_reset),
    .clr_flags  (cmd_err_clr),
    .wr_en      (wr_ok),
    .wr_data    (rx_char),
    .wr_flags   (in_flags),
    .rd_en      (rd_pop),
    .head_data  (rd_data),
    .head_flags (head_flags),
    .full       (q_full),
    .empty      (q_empty)
  );

  rxq_errs u_errs (
    .clk       (clk),
    .rst       (rst),
    .clr_all   (cmd_rx_reset),
    .clr_err   (cmd_err_clr),
    .arrive    (arrive),
    .q_full    (q_full),
    .popping   (rd_pop),
    .new_flags (in_flags),
    .overrun   (overrun),
    .accum     (accum)
  );

  assign shown  = mode_block ? accum : head_flags;
  assign status = {shown, overrun, tx_empty_in, tx_ready_in, q_full, !q_empty};
  assign irq    = mode_irq_full ? q_full : !q_empty;
  assign rts    = mode_auto_rts ? !q_full : 1'b1;

  // R2
  idle_rx_chk: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !rd_pop && !cmd_rx_reset) |=> ($stable(q_empty) && $stable(q_full)));

  // R9
  rx_reset_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_rx_reset |=> (q_empty && !overrun && accum == '0 && !rx_en));
endmodule

// File: tb/uart_rxq_stat_test.sv
`timescale 1ns/1ps
module uart_rxq_stat_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 0, rx_ferr = 0, rx_perr = 0, rx_brk = 0;
  logic [7:0] rx_char = '0;
  logic cmd_rx_on = 0, cmd_rx_off = 0, cmd_rx_reset = 0, cmd_err_clr = 0;
  logic mode_block = 0, mode_irq_full = 0, mode_auto_rts = 0;
  logic rd_pop = 0, tx_empty_in = 1, tx_ready_in = 0;
  logic [7:0] rd_data, status;
  logic irq, rts;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  uart_rxq_stat uut (.*);

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // status image: flags {brk,ferr,perr}, overrun, tx_empty=1, tx_ready=0, full, ready
  function automatic logic [7:0] st(input logic [2:0] f, input logic o,
                                    input logic fu, input logic rdy);
    return {f, o, 1'b1, 1'b0, fu, rdy};
  endfunction

  task automatic push(input logic [7:0] c, input logic [2:0] f);
    rx_valid = 1; rx_char = c; {rx_brk, rx_ferr, rx_perr} = f;
    cyc();
    rx_valid = 0; {rx_brk, rx_ferr, rx_perr} = '0;
  endtask

  task automatic pop();
    rd_pop = 1; cyc(); rd_pop = 0;
  endtask

  task automatic cmd_on();  cmd_rx_on = 1;    cyc(); cmd_rx_on = 0;    endtask
  task automatic cmd_rst(); cmd_rx_reset = 1; cyc(); cmd_rx_reset = 0; endtask
  task automatic cmd_clr(); cmd_err_clr = 1;  cyc(); cmd_err_clr = 0;  endtask

  task automatic t_reset();
    chk("R1 status", status, st(3'b000, 0, 0, 0));
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 rts", {7'b0, rts}, 8'h01);
    chk("R4 tx mirror", status[3:2], 2'b10);
  endtask

  task automatic t_enable();
    push(8'h11, 3'b000);
    chk("R2 disabled ignores", status, st(3'b000, 0, 0, 0));
    cmd_rx_on = 1; cmd_rx_off = 1; cyc(); cmd_rx_on = 0; cmd_rx_off = 0;
    push(8'h12, 3'b000);
    chk("R2 off wins", status, st(3'b000, 0, 0, 0));
    cmd_on();
    push(8'h13, 3'b000);
    chk("R2 enabled stores", rd_data, 8'h13);
    pop();
    chk("R3 drained", status, st(3'b000, 0, 0, 0));
  endtask

  task automatic t_order_overrun();
    push(8'hA1, 3'b010);
    push(8'hB2, 3'b000);
    push(8'hC3, 3'b100);
    chk("R4 full", status, st(3'b010, 0, 1, 1));
    chk("R5 head flags", status[7:5], 3'b010);
    push(8'hD4, 3'b001);
    chk("R7 overrun set", status, st(3'b010, 1, 1, 1));
    chk("R7 head kept", rd_data, 8'hA1);
    pop();
    chk("R3 second", rd_data, 8'hB2);
    chk("R5 flags follow", status, st(3'b000, 1, 0, 1));
    pop();
    chk("R3 third", rd_data, 8'hC3);
    chk("R5 break head", status[7:5], 3'b100);
    pop();
    chk("R7 dropped char absent", rd_data, 8'h00);
    chk("R7 overrun sticky", status, st(3'b000, 1, 0, 0));
    pop();
    chk("R3 pop empty", status, st(3'b000, 1, 0, 0));
    cmd_clr();
    chk("R8 overrun cleared", status, st(3'b000, 0, 0, 0));
  endtask

  task automatic t_block();
    mode_block = 1;
    push(8'h21, 3'b001);
    push(8'h22, 3'b000);
    pop(); pop();
    chk("R6 sticky after reads", status, st(3'b001, 0, 0, 0));
    push(8'h23, 3'b100);
    chk("R6 accumulate", status[7:5], 3'b101);
    cmd_clr();
    chk("R8 accum cleared", status, st(3'b000, 0, 0, 1));
    chk("R8 data kept", rd_data, 8'h23);
    pop();
    mode_block = 0;
  endtask

  task automatic t_clr_stored();
    push(8'h31, 3'b011);
    cmd_clr();
    chk("R8 stored flags cleared", status, st(3'b000, 0, 0, 1));
    chk("R8 stored data", rd_data, 8'h31);
    pop();
  endtask

  task automatic t_irq_rts();
    mode_irq_full = 1; mode_auto_rts = 1;
    push(8'h41, 3'b000);
    chk("R10 irq full-mode partial", {7'b0, irq}, 8'h00);
    mode_irq_full = 0; #1;
    chk("R10 irq ready-mode", {7'b0, irq}, 8'h01);
    mode_irq_full = 1;
    push(8'h42, 3'b000);
    chk("R11 rts room", {7'b0, rts}, 8'h01);
    push(8'h43, 3'b000);
    chk("R10 irq full", {7'b0, irq}, 8'h01);
    chk("R11 rts negated", {7'b0, rts}, 8'h00);
    // R12: arrival plus pop on a full queue
    rd_pop = 1; rx_valid = 1; rx_char = 8'h44; cyc(); rd_pop = 0; rx_valid = 0;
    chk("R12 no overrun", status, st(3'b000, 0, 1, 1));
    chk("R12 head advanced", rd_data, 8'h42);
    pop();
    chk("R12 order", rd_data, 8'h43);
    chk("R11 rts back", {7'b0, rts}, 8'h01);
    pop();
    chk("R12 new tail", rd_data, 8'h44);
    pop();
    mode_auto_rts = 0;
    chk("R11 rts manual", {7'b0, rts}, 8'h01);
    mode_irq_full = 0;
  endtask

  task automatic t_rx_reset();
    push(8'h51, 3'b100);
    push(8'h52, 3'b000);
    push(8'h53, 3'b000);
    push(8'h54, 3'b000);
    chk("R9 precondition", status, st(3'b100, 1, 1, 1));
    cmd_rx_reset = 1; rd_pop = 1; cyc(); cmd_rx_reset = 0; rd_pop = 0;
    chk("R9 cleared", status, st(3'b000, 0, 0, 0));
    push(8'h55, 3'b000);
    chk("R9 disabled after", status, st(3'b000, 0, 0, 0));
  endtask

  initial begin
    #3000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(); cyc();
    rst = 0;
    cyc();
    t_reset();
    t_enable();
    t_order_overrun();
    t_block();
    t_clr_stored();
    t_irq_rts();
    t_rx_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule